// File: doc/BRIEF.md
# Audio port interrupt flag unit

This block gathers the event and error indications of one serial audio sub-block and turns them into seven status flags, a per-source enable mask and one combined interrupt line. Six flags are sticky error or event flags. Each one is raised by a one-cycle pulse from the datapath, but only when the current operating mode allows that source. The mode is set by the role (master or slave), the direction (transmit or receive), the protocol (free/I2S-like, AC'97 or SPDIF) and whether the clock divider is bypassed. The seventh flag follows the FIFO request level that the datapath supplies and has no software clear.

Software uses a small register port. Address 0 holds the enable mask. Address 1 is a write-one-to-clear register. Address 2 is the read-only status view. The block also produces a DMA request from the FIFO request level, but only while DMA is enabled and the interface is enabled.

Top module: `audio_irq_unit`

## Requirements
- R1: While `rstN` is low, all flags, the enable mask, `irqOut` and `dmaReq` are held at 0.
- R2: A write to address 0 stores `regWrData` as the enable mask, and a read of address 0 returns it. Bit order in the mask, the clear register and the status view: 0 FIFO request, 1 overrun/underrun, 2 early frame sync, 3 late frame sync, 4 codec not ready, 5 mute detected, 6 clock configuration error.
- R3: Error flags (bits 1 to 6) are sticky. A flag is set at the clock edge that samples a qualified event pulse, and it stays set until it is cleared.
- R4: Writing 1 to a bit of address 1 clears the matching error flag at that edge. Writing 0 there has no effect. Reading address 1 always returns 0.
- R5: If a qualified event pulse and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R6: The early and late frame-sync flags are raised only in slave role (`isMaster`=0) with `protoMode` being neither AC'97 (1) nor SPDIF (2). Mode 0 is free and mode 3 is treated as free.
- R7: The codec-not-ready flag is raised only in slave role with `protoMode` = 1 (AC'97).
- R8: The mute flag is raised only when `isReceiver`=1, in either role.
- R9: The clock configuration flag is raised only when `isMaster`=1 and `divBypass`=0.
- R10: The overrun/underrun flag is raised in every role, direction and protocol.
- R11: Status bit 0 equals `fifoReqLevel` as sampled at the previous edge. Writing to the clear register does not change it.
- R12: `irqOut` is a register. It equals the OR over all seven sources of (flag AND mask bit), as held in the previous cycle.
- R13: `dmaReq` is a register. It equals `fifoReqLevel` AND `dmaEnable` AND `ifEnable`, as sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| evtOvrUdr | input | 1 | Overrun/underrun pulse |
| evtEarlySync | input | 1 | Early frame-sync pulse |
| evtLateSync | input | 1 | Late frame-sync pulse |
| evtCodecNotReady | input | 1 | Codec-not-ready pulse |
| evtMute | input | 1 | Mute-detected pulse |
| evtClkCfg | input | 1 | Bad clock configuration pulse |
| fifoReqLevel | input | 1 | FIFO threshold request level |
| isMaster | input | 1 | 1 = master role, 0 = slave |
| isReceiver | input | 1 | 1 = receive, 0 = transmit |
| protoMode | input | 2 | 0 free, 1 AC'97, 2 SPDIF, 3 treated as free |
| divBypass | input | 1 | 1 = clock divider bypassed |
| ifEnable | input | 1 | Interface enable |
| dmaEnable | input | 1 | DMA enable |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 mask, 1 clear, 2 status) |
| regWrData | input | 7 | Write data |
| regRdData | output | 7 | Read data for `regAddr` (combinational) |
| irqOut | output | 1 | Combined interrupt |
| dmaReq | output | 1 | DMA request |

## Verification
On every cycle, the assertions check that flags stay sticky without a clear, that a clear empties an idle flag, that a set wins over a same-cycle clear, and that a rising flag always had its mode qualification in the previous cycle. They also check that the FIFO flag, `irqOut` and `dmaReq` follow their sources one cycle later. Only the bench scenarios can show that a source is actually raised in every mode that allows it, across all 32 mode combinations. The same holds for mask readback, for the zero returned when the clear register is read, and for the exact cycle on which the interrupt rises and falls after a set or a clear.

// File: rtl/audirq_pkg.sv
package audirq_pkg;
  localparam int NUM_SRC = 7;
  localparam int ADDR_W  = 2;

  localparam int SRC_FIFO   = 0;
  localparam int SRC_OVR    = 1;
  localparam int SRC_EARLY  = 2;
  localparam int SRC_LATE   = 3;
  localparam int SRC_CNRDY  = 4;
  localparam int SRC_MUTE   = 5;
  localparam int SRC_CLKCFG = 6;

  typedef enum logic [1:0] {
    PROTO_FREE  = 2'd0,
    PROTO_AC97  = 2'd1,
    PROTO_SPDIF = 2'd2,
    PROTO_RSVD  = 2'd3
  } proto_e;

  typedef enum logic [ADDR_W-1:0] {
    REG_MASK   = 2'd0,
    REG_CLEAR  = 2'd1,
    REG_STATUS = 2'd2,
    REG_SPARE  = 2'd3
  } regsel_e;

  typedef struct packed {
    logic               maskWr;
    logic [NUM_SRC-1:0] wrData;
    logic [NUM_SRC-1:0] clrBits;
    regsel_e            rdSel;
  } ctrl_strobes_t;
endpackage

// File: rtl/audirq_ctrl.sv
module audirq_ctrl
  import audirq_pkg::*;
(
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output ctrl_strobes_t      strobes
);
  localparam logic [NUM_SRC-1:0] CLEARABLE = ~(NUM_SRC'(1) << SRC_FIFO);

  regsel_e sel;

  always_comb begin
    sel             = regsel_e'(regAddr);
    strobes.maskWr  = regWrEn && (sel == REG_MASK);
    strobes.wrData  = regWrData;
    strobes.clrBits = (regWrEn && (sel == REG_CLEAR)) ? (regWrData & CLEARABLE) : '0;
    strobes.rdSel   = sel;
  end
endmodule

// File: rtl/audirq_flags.sv
module audirq_flags
  import audirq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobes_t      strobes,
  input  logic [NUM_SRC-1:0] evtVec,
  input  logic               fifoLevel,
  input  logic               isMaster,
  input  logic               isReceiver,
  input  logic [1:0]         protoMode,
  input  logic               divBypass,
  input  logic               ifEnable,
  input  logic               dmaEnable,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut,
  output logic               dmaReq
);
  logic [NUM_SRC-1:0] qual;
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] flagsNext;
  logic [NUM_SRC-1:0] maskReg;
  logic               slaveFree;
  logic               irqReg;
  logic               dmaReg;
  logic               pastValid;
  proto_e             proto;

  always_comb begin
    proto             = proto_e'(protoMode);
    slaveFree         = !isMaster && (proto != PROTO_AC97) && (proto != PROTO_SPDIF);
    qual              = '0;
    qual[SRC_OVR]     = 1'b1;
    qual[SRC_EARLY]   = slaveFree;
    qual[SRC_LATE]    = slaveFree;
    qual[SRC_CNRDY]   = !isMaster && (proto == PROTO_AC97);
    qual[SRC_MUTE]    = isReceiver;
    qual[SRC_CLKCFG]  = isMaster && !divBypass;
  end

  assign flagsNext[SRC_FIFO] = fifoLevel;

  for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
    assign flagsNext[i] = (evtVec[i] && qual[i]) ? 1'b1 :
                          strobes.clrBits[i]      ? 1'b0 : flags[i];

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !strobes.clrBits[i]) |=> flags[i]);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clrBits[i] && !evtVec[i]) |=> !flags[i]);
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clrBits[i] && evtVec[i] && qual[i]) |=> flags[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags     <= '0;
      maskReg   <= '0;
      irqReg    <= 1'b0;
      dmaReg    <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      flags     <= flagsNext;
      if (strobes.maskWr) maskReg <= strobes.wrData;
      irqReg    <= |(flags & maskReg);
      dmaReg    <= fifoLevel && dmaEnable && ifEnable;
      pastValid <= 1'b1;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      REG_MASK:   rdData = maskReg;
      REG_STATUS: rdData = flags;
      default:    rdData = '0;
    endcase
  end

  assign irqOut = irqReg;
  assign dmaReq = dmaReg;

  p_reset_r1: assert property (@(posedge clk)
    !rstN |=> (flags == '0 && maskReg == '0 && !irqOut && !dmaReq));
  p_early_mode_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[SRC_EARLY]) |-> $past(!isMaster && protoMode != 2'd1 && protoMode != 2'd2));
  p_late_mode_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[SRC_LATE]) |-> $past(!isMaster && protoMode != 2'd1 && protoMode != 2'd2));
  p_cnrdy_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[SRC_CNRDY]) |-> $past(!isMaster && protoMode == 2'd1));
  p_mute_rx_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[SRC_MUTE]) |-> $past(isReceiver));
  p_clkcfg_mode_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[SRC_CLKCFG]) |-> $past(isMaster && !divBypass));
  p_fifo_follow_r11: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (flags[SRC_FIFO] == $past(fifoLevel)));
  p_irq_source_r12: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(|(flags & maskReg)));
  p_dma_gate_r13: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> $past(dmaEnable && ifEnable && fifoLevel));
endmodule

// File: rtl/audio_irq_unit.sv
module audio_irq_unit
  import audirq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               evtOvrUdr,
  input  logic               evtEarlySync,
  input  logic               evtLateSync,
  input  logic               evtCodecNotReady,
  input  logic               evtMute,
  input  logic               evtClkCfg,
  input  logic               fifoReqLevel,
  input  logic               isMaster,
  input  logic               isReceiver,
  input  logic [1:0]         protoMode,
  input  logic               divBypass,
  input  logic               ifEnable,
  input  logic               dmaEnable,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  output logic               irqOut,
  output logic               dmaReq
);
  ctrl_strobes_t      strobes;
  logic [NUM_SRC-1:0] evtVec;

  always_comb begin
    evtVec             = '0;
    evtVec[SRC_OVR]    = evtOvrUdr;
    evtVec[SRC_EARLY]  = evtEarlySync;
    evtVec[SRC_LATE]   = evtLateSync;
    evtVec[SRC_CNRDY]  = evtCodecNotReady;
    evtVec[SRC_MUTE]   = evtMute;
    evtVec[SRC_CLKCFG] = evtClkCfg;
  end

  audirq_ctrl u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobes   (strobes)
  );

  audirq_flags u_flags (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .evtVec     (evtVec),
    .fifoLevel  (fifoReqLevel),
    .isMaster   (isMaster),
    .isReceiver (isReceiver),
    .protoMode  (protoMode),
    .divBypass  (divBypass),
    .ifEnable   (ifEnable),
    .dmaEnable  (dmaEnable),
    .rdData     (regRdData),
    .irqOut     (irqOut),
    .dmaReq     (dmaReq)
  );
endmodule

// File: tb/audio_irq_unit_test.sv
module audio_irq_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] evt = '0;
  logic       fifoReqLevel = 1'b0;
  logic       isMaster = 1'b0;
  logic       isReceiver = 1'b0;
  logic [1:0] protoMode = 2'd0;
  logic       divBypass = 1'b0;
  logic       ifEnable = 1'b0;
  logic       dmaEnable = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [6:0] regWrData = '0;
  logic [6:0] regRdData;
  logic       irqOut;
  logic       dmaReq;
  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  audio_irq_unit uut (
    .clk(clk), .rstN(rstN),
    .evtOvrUdr(evt[1]), .evtEarlySync(evt[2]), .evtLateSync(evt[3]),
    .evtCodecNotReady(evt[4]), .evtMute(evt[5]), .evtClkCfg(evt[6]),
    .fifoReqLevel(fifoReqLevel), .isMaster(isMaster), .isReceiver(isReceiver),
    .protoMode(protoMode), .divBypass(divBypass), .ifEnable(ifEnable),
    .dmaEnable(dmaEnable), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut), .dmaReq(dmaReq)
  );

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [6:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [6:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input logic [6:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic tReset;
    logic [6:0] v;
    readReg(2'd2, v); check("R1 status", v, 7'h00);
    readReg(2'd0, v); check("R1 mask", v, 7'h00);
    check("R1 irq", {6'd0, irqOut}, 7'd0);
    check("R1 dma", {6'd0, dmaReq}, 7'd0);
  endtask

  task automatic tMask;
    logic [6:0] v;
    wrReg(2'd0, 7'h55); readReg(2'd0, v); check("R2 mask 55", v, 7'h55);
    wrReg(2'd0, 7'h2A); readReg(2'd0, v); check("R2 mask 2A", v, 7'h2A);
    wrReg(2'd0, 7'h00);
  endtask

  task automatic tSticky;
    logic [6:0] v;
    isMaster = 1'b1; isReceiver = 1'b0; protoMode = 2'd2; divBypass = 1'b1;
    pulse(7'h02);
    repeat (5) @(negedge clk);
    readReg(2'd2, v); check("R3 sticky ovr", v, 7'h02);
    readReg(2'd1, v); check("R4 clear reads zero", v, 7'h00);
    wrReg(2'd1, 7'h00); readReg(2'd2, v); check("R4 write zero no effect", v, 7'h02);
    wrReg(2'd1, 7'h02); readReg(2'd2, v); check("R4 w1c", v, 7'h00);
  endtask

  task automatic tSetWins;
    logic [6:0] v;
    isMaster = 1'b0; protoMode = 2'd0;
    evt = 7'h02; regWrEn = 1'b1; regAddr = 2'd1; regWrData = 7'h02;
    @(negedge clk);
    evt = '0; regWrEn = 1'b0; regWrData = '0;
    readReg(2'd2, v); check("R5 set wins", v, 7'h02);
    wrReg(2'd1, 7'h7E); readReg(2'd2, v); check("R5 cleared after", v, 7'h00);
  endtask

  task automatic tQual;
    logic [6:0] v;
    logic [6:0] e;
    for (int k = 0; k < 32; k++) begin
      isMaster = k[0]; isReceiver = k[1]; protoMode = k[3:2]; divBypass = k[4];
      e = 7'h02;
      e[2] = !k[0] && k[3:2] != 2'd1 && k[3:2] != 2'd2;
      e[3] = e[2];
      e[4] = !k[0] && k[3:2] == 2'd1;
      e[5] = k[1];
      e[6] = k[0] && !k[4];
      pulse(7'h7E);
      readReg(2'd2, v);
      check("R6 early/late slave non-AC97/SPDIF", v & 7'h0C, e & 7'h0C);
      check("R7 cnrdy slave AC97", v & 7'h10, e & 7'h10);
      check("R8 mute receiver", v & 7'h20, e & 7'h20);
      check("R9 clkcfg master no bypass", v & 7'h40, e & 7'h40);
      check("R10 ovr any mode", v & 7'h02, 7'h02);
      wrReg(2'd1, 7'h7E);
    end
  endtask

  task automatic tFifo;
    logic [6:0] v;
    fifoReqLevel = 1'b1;
    readReg(2'd2, v); check("R11 not yet", v & 7'h01, 7'h00);
    @(negedge clk);
    readReg(2'd2, v); check("R11 follows level", v & 7'h01, 7'h01);
    wrReg(2'd1, 7'h01); readReg(2'd2, v); check("R11 no clear", v & 7'h01, 7'h01);
    fifoReqLevel = 1'b0;
    @(negedge clk);
    readReg(2'd2, v); check("R11 drops", v & 7'h01, 7'h00);
  endtask

  task automatic tIrq;
    isMaster = 1'b1; isReceiver = 1'b1; protoMode = 2'd0; divBypass = 1'b0;
    wrReg(2'd0, 7'h00);
    pulse(7'h20);
    @(negedge clk);
    check("R12 masked no irq", {6'd0, irqOut}, 7'd0);
    wrReg(2'd0, 7'h20);
    check("R12 irq one cycle after mask", {6'd0, irqOut}, 7'd0);
    @(negedge clk);
    check("R12 irq rises", {6'd0, irqOut}, 7'd1);
    wrReg(2'd1, 7'h20);
    check("R12 irq held cycle of clear", {6'd0, irqOut}, 7'd1);
    @(negedge clk);
    check("R12 irq falls", {6'd0, irqOut}, 7'd0);
    wrReg(2'd0, 7'h01);
    fifoReqLevel = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 irq from fifo", {6'd0, irqOut}, 7'd1);
    fifoReqLevel = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 irq fifo gone", {6'd0, irqOut}, 7'd0);
    wrReg(2'd0, 7'h00);
  endtask

  task automatic tDma;
    fifoReqLevel = 1'b1; dmaEnable = 1'b1; ifEnable = 1'b0;
    @(negedge clk);
    check("R13 no dma iface off", {6'd0, dmaReq}, 7'd0);
    ifEnable = 1'b1;
    @(negedge clk);
    check("R13 dma on", {6'd0, dmaReq}, 7'd1);
    dmaEnable = 1'b0;
    @(negedge clk);
    check("R13 dma disabled", {6'd0, dmaReq}, 7'd0);
    dmaEnable = 1'b1; fifoReqLevel = 1'b0;
    @(negedge clk);
    check("R13 no level", {6'd0, dmaReq}, 7'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset;
    rstN = 1'b1;
    @(negedge clk);
    tReset;
    tMask;
    tSticky;
    tSetWins;
    tQual;
    tFifo;
    tIrq;
    tDma;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule